// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It holds recent virtual-page-to-physical-frame mappings so that most address translations finish without reading the page table from main memory. Each entry is tagged with an address-space identifier (ASID). An entry only serves the process whose identifier matches it, so several processes can keep their mappings in the buffer together and a context switch does not need a flush.

A lookup presents a virtual address and the current ASID. One cycle later the block reports whether it hit. On a hit it also gives the physical address, built from the stored frame number and the untouched page offset. On a miss, a separate page-table walker fetches the mapping and writes it back through the refill port. A flush input can drop every entry, or only the entries of one ASID.

With the defaults the buffer has 16 entries, 4 KiB pages, 32-bit virtual and physical addresses and 8-bit ASIDs.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and `rsp_valid` and `rsp_hit` are low.
- R2: A lookup request accepted on one clock edge is answered on the following edge: `rsp_valid` is high for that one cycle. The lookup sees the contents from before that edge, so a refill in the same cycle is not visible to it.
- R3: A lookup hits only when an entry is valid, its page number equals `lk_vaddr[31:12]` and its ASID equals `lk_asid`. The physical address is then {stored frame, `lk_vaddr[11:0]`}.
- R4: A miss reports `rsp_hit` low and `rsp_paddr` zero.
- R5: A refill with no matching entry goes into the lowest-numbered invalid entry, if there is one. It evicts nothing and does not move the replacement pointer.
- R6: When all entries are valid, a refill replaces the entry at a round-robin pointer. The pointer starts at 0, steps by one after each such replacement, and wraps from the last entry to 0.
- R7: A refill whose page number and ASID are already held overwrites that entry with the new frame. No other entry is touched, the pointer does not move, and no duplicate is created.
- R8: A per-ASID flush invalidates exactly the entries with that ASID in one cycle. Entries of other ASIDs keep hitting.
- R9: A global flush invalidates every entry in one cycle.
- R10: A flush of either kind takes precedence over a refill in the same cycle. That refill is dropped.
- R11: The same page number can be held for different ASIDs at once, each returning its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | ASID of the current process |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address, zero on miss |
| fill_en | input | 1 | Write a new mapping |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_asid | input | 8 | ASID of the mapping |
| fill_pfn | input | 20 | Physical frame number of the mapping |
| flush_all | input | 1 | Invalidate all entries |
| flush_one | input | 1 | Invalidate the entries of `flush_asid` |
| flush_asid | input | 8 | ASID selected by `flush_one` |

## Verification
The bench targets these corner cases and the failure each would show:
- Right page with the wrong ASID: a design that ignored the tag would hit.
- A hole left by a per-ASID flush: a design that ignored free slots would refill at the pointer and evict a live page.
- A refill of a page that is already held: a design without the in-place path would evict another entry through the pointer, or leave two entries that both match.
- Pointer stepping and wrap over a full sweep: an off-by-one or a missing wrap evicts the wrong page.
- A refill in the same cycle as a lookup or a flush: a design that got the ordering wrong would hit too early or keep an entry that should have been dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where a refill lands
    typedef enum logic [1:0] {
        FILL_SAME = 2'd0,   // overwrite an entry already holding the key
        FILL_FREE = 2'd1,   // lowest invalid entry
        FILL_RR   = 2'd2    // round-robin victim
    } fill_src_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               ent_valid,
    input  logic [N-1:0][VPN_W-1:0]    ent_vpn,
    input  logic [N-1:0][ASID_W-1:0]   ent_asid,
    input  logic [VPN_W-1:0]           key_vpn,
    input  logic [ASID_W-1:0]          key_asid,
    output logic [N-1:0]               hit_vec
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i]
                          && (ent_vpn[i] == key_vpn)
                          && (ent_asid[i] == key_asid);
    end

    // R7
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     ent_valid,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic             has_free,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
        victim_idx = has_free ? free_idx : rr_ptr;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [ASID_W-1:0] flush_asid
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [IDX_W-1:0]               ptr;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [PA_W-1:0]                rsp_paddr;
    } tlb_state_t;

    tlb_state_t s_d, s_q;

    logic [ENTRIES-1:0] lk_hit_vec, fill_hit_vec;
    logic               has_free;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   same_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic [PFN_W-1:0]   sel_pfn;
    fill_src_e          fill_src;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (s_q.valid),
        .ent_vpn   (s_q.vpn),
        .ent_asid  (s_q.asid),
        .key_vpn   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .key_asid  (lk_asid),
        .hit_vec   (lk_hit_vec)
    );

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (s_q.valid),
        .ent_vpn   (s_q.vpn),
        .ent_asid  (s_q.asid),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .hit_vec   (fill_hit_vec)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .ent_valid  (s_q.valid),
        .rr_ptr     (s_q.ptr),
        .has_free   (has_free),
        .victim_idx (victim_idx)
    );

    // Frame select and one-hot to index encode
    always_comb begin
        sel_pfn  = '0;
        same_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i])   sel_pfn  = sel_pfn | s_q.pfn[i];
            if (fill_hit_vec[i]) same_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|fill_hit_vec) begin
            fill_src = FILL_SAME;
            fill_idx = same_idx;
        end else if (has_free) begin
            fill_src = FILL_FREE;
            fill_idx = victim_idx;
        end else begin
            fill_src = FILL_RR;
            fill_idx = victim_idx;
        end
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;

        s_d.rsp_valid = lk_req;
        s_d.rsp_hit   = lk_req && (|lk_hit_vec);
        s_d.rsp_paddr = (lk_req && (|lk_hit_vec))
                      ? {sel_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;

        if (flush_all) begin
            s_d.valid = '0;
        end else if (flush_one) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_q.asid[i] == flush_asid) s_d.valid[i] = 1'b0;
            end
        end else if (fill_en) begin
            s_d.valid[fill_idx] = 1'b1;
            s_d.vpn[fill_idx]   = fill_vpn;
            s_d.asid[fill_idx]  = fill_asid;
            s_d.pfn[fill_idx]   = fill_pfn;
            if (fill_src == FILL_RR) begin
                s_d.ptr = (s_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_paddr = s_q.rsp_paddr;

    // R9
    global_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (s_q.valid == '0));

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));

    // R5
    free_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_one && !(&s_q.valid) && !(|fill_hit_vec))
        |=> ($countones(s_q.valid) == $countones($past(s_q.valid)) + 1));

    // R10
    flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_one && fill_en)
        |=> ($countones(s_q.valid) <= $countones($past(s_q.valid))));

endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush_all = 1'b0;
    logic        flush_one = 1'b0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .flush_all(flush_all), .flush_one(flush_one), .flush_asid(flush_asid)
    );

    // {vaddr, asid, expected hit, expected paddr}
    localparam logic [72:0] TBL [8] = '{
        {32'h0000_0ABC, 8'd1, 1'b1, 32'h0010_0ABC},
        {32'h0000_3123, 8'd1, 1'b1, 32'h0010_3123},
        {32'h0000_5FFF, 8'd2, 1'b1, 32'h0010_5FFF},
        {32'h0000_5FFF, 8'd1, 1'b0, 32'h0000_0000},
        {32'h0000_F000, 8'd1, 1'b1, 32'h0010_F000},
        {32'h0001_0000, 8'd1, 1'b0, 32'h0000_0000},
        {32'h0000_3123, 8'd7, 1'b0, 32'h0000_0000},
        {32'hFFFF_F001, 8'd1, 1'b0, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] as,
                          output logic v, output logic h, output logic [31:0] pa);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = as;
        @(negedge clk);
        lk_req = 1'b0;
        v = rsp_valid; h = rsp_hit; pa = rsp_paddr;
    endtask

    task automatic expect_map(input string tag, input logic [19:0] vpn, input logic [7:0] as,
                              input logic hit, input logic [19:0] pfn);
        logic v, h;
        logic [31:0] pa;
        lookup({vpn, 12'h5A5}, as, v, h, pa);
        check(tag, {v, h}, {1'b1, hit});
        check(tag, pa, hit ? {pfn, 12'h5A5} : 32'h0);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] as, input logic [19:0] pfn);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_asid = as; fill_pfn = pfn;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush(input logic all, input logic [7:0] as);
        @(negedge clk);
        flush_all = all; flush_one = !all; flush_asid = as;
        @(negedge clk);
        flush_all = 1'b0; flush_one = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v, h;
        logic [31:0] pa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rsp after reset", {rsp_valid, rsp_hit}, 2'b00);
        expect_map("R1 empty miss", 20'h0, 8'd0, 1'b0, 20'h0);

        // R5: fill 16 entries, vpn i, ASID 2 for vpn 5 else 1
        for (int i = 0; i < 16; i++)
            fill(20'(i), (i == 5) ? 8'd2 : 8'd1, 20'h100 + 20'(i));

        // R3 R4: table walk
        for (int k = 0; k < 8; k++) begin
            lookup(TBL[k][72:41], TBL[k][40:33], v, h, pa);
            check($sformatf("R3 vec %0d", k), {v, h}, {1'b1, TBL[k][32]});
            check($sformatf("R4 vec %0d paddr", k), pa, TBL[k][31:0]);
        end

        // R8: flush ASID 2 only
        flush(1'b0, 8'd2);
        expect_map("R8 flushed asid", 20'h5, 8'd2, 1'b0, 20'h0);
        expect_map("R8 other asid kept", 20'h4, 8'd1, 1'b1, 20'h104);

        // R5: refill goes into the hole, pointer still at 0
        fill(20'h40, 8'd1, 20'h440);
        expect_map("R5 hole filled", 20'h40, 8'd1, 1'b1, 20'h440);
        expect_map("R5 entry0 kept", 20'h0, 8'd1, 1'b1, 20'h100);

        // R6: full, pointer replacement
        fill(20'h41, 8'd1, 20'h441);
        expect_map("R6 entry0 evicted", 20'h0, 8'd1, 1'b0, 20'h0);
        expect_map("R6 new hit", 20'h41, 8'd1, 1'b1, 20'h441);
        fill(20'h42, 8'd1, 20'h442);
        expect_map("R6 entry1 evicted", 20'h1, 8'd1, 1'b0, 20'h0);

        // R7: overwrite existing key in place
        fill(20'h7, 8'd1, 20'h777);
        expect_map("R7 new frame", 20'h7, 8'd1, 1'b1, 20'h777);
        expect_map("R7 no eviction", 20'h2, 8'd1, 1'b1, 20'h102);
        fill(20'h43, 8'd1, 20'h443);
        expect_map("R7 pointer unmoved", 20'h2, 8'd1, 1'b0, 20'h0);
        expect_map("R6 entry3 kept", 20'h3, 8'd1, 1'b1, 20'h103);

        // R6: wrap around
        for (int k = 0; k < 14; k++) fill(20'h50 + 20'(k), 8'd1, 20'h500 + 20'(k));
        expect_map("R6 wrap evicts entry0", 20'h41, 8'd1, 1'b0, 20'h0);
        expect_map("R6 wrap keeps entry1", 20'h42, 8'd1, 1'b1, 20'h442);

        // R9: global flush
        flush(1'b1, 8'd0);
        expect_map("R9 all gone a", 20'h42, 8'd1, 1'b0, 20'h0);
        expect_map("R9 all gone b", 20'h5D, 8'd1, 1'b0, 20'h0);

        // R11: same page, two ASIDs
        fill(20'h9, 8'd1, 20'hAAAAA);
        fill(20'h9, 8'd3, 20'hBBBBB);
        expect_map("R11 asid1", 20'h9, 8'd1, 1'b1, 20'hAAAAA);
        expect_map("R11 asid3", 20'h9, 8'd3, 1'b1, 20'hBBBBB);
        flush(1'b0, 8'd3);
        expect_map("R8 asid3 gone", 20'h9, 8'd3, 1'b0, 20'h0);
        expect_map("R8 asid1 kept", 20'h9, 8'd1, 1'b1, 20'hAAAAA);

        // R10: flush beats refill
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h20; fill_asid = 8'd1; fill_pfn = 20'h220;
        flush_one = 1'b1; flush_asid = 8'd5;
        @(negedge clk);
        fill_en = 1'b0; flush_one = 1'b0;
        expect_map("R10 per-asid flush drops fill", 20'h20, 8'd1, 1'b0, 20'h0);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h21; flush_all = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0;
        expect_map("R10 global flush drops fill", 20'h21, 8'd1, 1'b0, 20'h0);

        // R2: same-cycle refill not seen, then seen; valid only one cycle
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = 32'h0003_0010; lk_asid = 8'd4;
        fill_en = 1'b1; fill_vpn = 20'h30; fill_asid = 8'd4; fill_pfn = 20'h330;
        @(negedge clk);
        lk_req = 1'b0; fill_en = 1'b0;
        check("R2 same-cycle fill invisible", {rsp_valid, rsp_hit}, 2'b10);
        @(negedge clk);
        check("R2 valid one cycle", {rsp_valid, rsp_hit}, 2'b00);
        expect_map("R2 visible next", 20'h30, 8'd4, 1'b1, 20'h330);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule